// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a down-counting watchdog that software can start, refresh and, in one build variant, stop, but only by writing two fixed 32-bit key words in a strict order to its control register. The first word of each pair arms the action. The second word, written immediately after it, carries the action out. Any other write in between cancels the pending action. Once started, the counter reloads to its full value and then counts down by one every clock. If it reaches zero before it is refreshed, the block issues a one-cycle reset request and stops.

A configuration register selects the kind of reset the request asks for. The same register can also ask for a reset at once, without waiting for the count to run out. A reset-cause register tells software after a restart whether the watchdog caused it. This register is cleared only by power-on reset or by a write-one-to-clear. A build parameter removes the ability to stop the timer. In that variant the stop keys act as a second spelling of the start keys, so a running timer can only be refreshed.

The block has two reset inputs. The power-on reset clears everything. The internal-bus reset is the one the request normally triggers, and it clears the counter and the key sequencer but leaves the configuration and the reset cause intact.

Top module: `keyed_watchdog`

## Requirements
- R1: Writing 0x1E1E1E1E and then, as the very next control write, 0xE1E1E1E1 enables the timer and loads the counter with RELOAD. Readback bit 0 reads 1 in the cycle after the second write.
- R2: Repeating the start pair while the timer runs reloads the counter. The reset request appears exactly RELOAD+1 cycles after the clock edge that captured the latest start commit, and not earlier.
- R3: With HAS_DISABLE=1, writing 0x1F1F1F1F and then 0xF1F1F1F1 stops the counter, and no reset request follows.
- R4: With HAS_DISABLE=0, 0x1F1F1F1F arms a start and 0xF1F1F1F1 commits a start, so the stop pair refreshes a running timer instead of stopping it.
- R5: A commit word that does not directly follow its matching arm word has no effect. Any control write other than an arm word clears the armed state.
- R6: On expiry the block drives rst_req high for exactly one cycle and clears the enabled state. Every rising edge of the request traces back to an expiry or an immediate-reset write.
- R7: Bit 5 of the reset-cause register is set together with every reset request. It survives the internal-bus reset, is cleared by writing 1 to bit 5 or by power-on reset, and is unaffected by writing 0 to bit 5.
- R8: Configuration bit 0 selects the reset kind (1 = internal-bus reset). It is read back at bit 0 and drives rst_kind. Bit 31 always reads 0.
- R9: A configuration write with bit 31 and bit 0 both set raises rst_req at the edge that captures the write and stops a running timer. A write with bit 31 set and bit 0 clear requests nothing.
- R10: Control readback is a state word: bit 0 enabled, bit 1 start armed, bit 2 stop armed, all other bits 0. At most one armed bit is set.
- R11: Internal-bus reset clears the enabled and armed state but keeps the configuration and the reset cause. Power-on reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock; the counter moves once per cycle |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst_n | input | 1 | Internal-bus reset, active low; spares configuration and cause |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control write data (key words) |
| ctl_rd_data | output | 32 | Control state readback |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 32 | Configuration write data: bit 0 reset kind, bit 31 immediate request |
| cfg_rd_data | output | 32 | Configuration readback |
| cause_wr_en | input | 1 | Reset-cause register write strobe (write one to clear) |
| cause_wr_data | input | 32 | Reset-cause write data |
| cause_rd_data | output | 32 | Reset-cause readback; bit 5 = last reset came from the watchdog |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 1 | Requested reset kind, 1 = internal-bus reset |

## Verification
Each write is captured at one rising edge, and the state readbacks change at that same edge. The bench therefore checks them at the falling edge right after the write's strobe cycle. An immediate-reset write shows rst_req at that same falling edge. An expiry is due RELOAD+1 edges after the commit edge. For an expiry, the bench checks that rst_req stays low at each of the first RELOAD falling edges and is high at the next one. A refresh moves that window to the newer commit. Checks that something does not happen, such as a stop, an ignored commit or a zero-write to the cause register, watch the request output for the whole window or read the state back directly after the write.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;

  localparam int REG_W = 32;

  // key words written to the control register
  localparam logic [REG_W-1:0] KEY_START_ARM = 32'h1E1E_1E1E;
  localparam logic [REG_W-1:0] KEY_START_GO  = 32'hE1E1_E1E1;
  localparam logic [REG_W-1:0] KEY_STOP_ARM  = 32'h1F1F_1F1F;
  localparam logic [REG_W-1:0] KEY_STOP_GO   = 32'hF1F1_F1F1;

  // field positions
  localparam int CFG_KIND_BIT  = 0;
  localparam int CFG_NOW_BIT   = 31;
  localparam int CAUSE_WD_BIT  = 5;
  localparam int STATE_EN_BIT  = 0;
  localparam int STATE_ARMS_BIT = 1;
  localparam int STATE_ARMX_BIT = 2;

  localparam logic [REG_W-1:0] CAUSE_MASK = REG_W'(1) << CAUSE_WD_BIT;

  typedef enum logic [1:0] {
    ARM_IDLE  = 2'd0,
    ARM_START = 2'd1,
    ARM_STOP  = 2'd2
  } armState_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic halt;
  } cntCmd_t;

endpackage

// File: rtl/kwd_ctrl.sv
`timescale 1ns/1ps
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter bit HAS_DISABLE = 1'b1
) (
  input  logic             clk,
  input  logic             porRst_n,
  input  logic             busRst_n,
  input  logic             ctlWrEn,
  input  logic [REG_W-1:0] ctlWrData,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             causeWrEn,
  input  logic [REG_W-1:0] causeWrData,
  input  logic             cntEnabled,
  input  logic             cntExpire,
  output cntCmd_t          cmd,
  output logic [REG_W-1:0] ctlRdData,
  output logic [REG_W-1:0] cfgRdData,
  output logic [REG_W-1:0] causeRdData,
  output logic             rstReq,
  output logic             rstKind
);

  logic softRst_n;
  assign softRst_n = porRst_n & busRst_n;

  // key decode; the parameter picks whether stop keys exist
  logic hitStartArm, hitStartGo, hitStopArm, hitStopGo;

  generate
    if (HAS_DISABLE) begin : g_stoppable
      assign hitStartArm = (ctlWrData == KEY_START_ARM);
      assign hitStartGo  = (ctlWrData == KEY_START_GO);
      assign hitStopArm  = (ctlWrData == KEY_STOP_ARM);
      assign hitStopGo   = (ctlWrData == KEY_STOP_GO);
    end else begin : g_locked
      assign hitStartArm = (ctlWrData == KEY_START_ARM) || (ctlWrData == KEY_STOP_ARM);
      assign hitStartGo  = (ctlWrData == KEY_START_GO)  || (ctlWrData == KEY_STOP_GO);
      assign hitStopArm  = 1'b0;
      assign hitStopGo   = 1'b0;
    end
  endgenerate

  // arm/commit sequencer
  armState_e armQ, armNext;
  logic      loadKey, stopKey;

  always_comb begin
    armNext = armQ;
    loadKey = 1'b0;
    stopKey = 1'b0;
    if (ctlWrEn) begin
      armNext = ARM_IDLE;
      if (hitStartArm) begin
        armNext = ARM_START;
      end else if (hitStopArm) begin
        armNext = ARM_STOP;
      end else if (hitStartGo && (armQ == ARM_START)) begin
        loadKey = 1'b1;
      end else if (hitStopGo && (armQ == ARM_STOP)) begin
        stopKey = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge softRst_n) begin
    if (!softRst_n) armQ <= ARM_IDLE;
    else            armQ <= armNext;
  end

  // configuration register (power-on domain)
  logic [REG_W-1:0] cfgQ;
  logic             nowReq;

  assign nowReq = cfgWrEn && cfgWrData[CFG_NOW_BIT] && cfgWrData[CFG_KIND_BIT];

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)    cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= {1'b0, cfgWrData[REG_W-2:0]};
  end

  // request pulse
  logic reqQ, reqNext;
  assign reqNext = (cntExpire || nowReq) && !reqQ;

  always_ff @(posedge clk or negedge softRst_n) begin
    if (!softRst_n) reqQ <= 1'b0;
    else            reqQ <= reqNext;
  end

  // reset-cause register (power-on domain, write one to clear)
  logic [REG_W-1:0] causeQ, causeNext;

  always_comb begin
    causeNext = causeQ;
    if (causeWrEn) causeNext = causeQ & ~causeWrData;
    if (reqNext)   causeNext[CAUSE_WD_BIT] = 1'b1;
    causeNext = causeNext & CAUSE_MASK;
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) causeQ <= '0;
    else           causeQ <= causeNext;
  end

  // outputs
  always_comb begin
    cmd.load = loadKey;
    cmd.halt = stopKey || nowReq;
  end

  always_comb begin
    ctlRdData = '0;
    ctlRdData[STATE_EN_BIT]   = cntEnabled;
    ctlRdData[STATE_ARMS_BIT] = (armQ == ARM_START);
    ctlRdData[STATE_ARMX_BIT] = (armQ == ARM_STOP);
  end

  assign cfgRdData   = cfgQ;
  assign causeRdData = causeQ;
  assign rstReq      = reqQ;
  assign rstKind     = cfgQ[CFG_KIND_BIT];

endmodule

// File: rtl/kwd_count.sv
`timescale 1ns/1ps
module kwd_count
  import kwd_pkg::*;
#(
  parameter int               CNT_W  = 32,
  parameter logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}}
) (
  input  logic    clk,
  input  logic    rst_n,
  input  cntCmd_t cmd,
  output logic    enabled,
  output logic    expire
);

  logic [CNT_W-1:0] cntQ;
  logic             enQ;
  logic             atZero;

  assign atZero = (cntQ == '0);
  assign expire = enQ && atZero && !cmd.load && !cmd.halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ  <= 1'b0;
      cntQ <= '0;
    end else if (cmd.load) begin
      enQ  <= 1'b1;
      cntQ <= RELOAD;
    end else if (cmd.halt || expire) begin
      enQ  <= 1'b0;
    end else if (enQ) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign enabled = enQ;

endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int               CNT_W       = 32,
  parameter logic [CNT_W-1:0] RELOAD      = {CNT_W{1'b1}},
  parameter bit               HAS_DISABLE = 1'b1
) (
  input  logic        clk,
  input  logic        por_rst_n,
  input  logic        bus_rst_n,
  input  logic        ctl_wr_en,
  input  logic [31:0] ctl_wr_data,
  output logic [31:0] ctl_rd_data,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  input  logic        cause_wr_en,
  input  logic [31:0] cause_wr_data,
  output logic [31:0] cause_rd_data,
  output logic        rst_req,
  output logic        rst_kind
);

  cntCmd_t cntCmd;
  logic    cntEnabled;
  logic    cntExpire;
  logic    softRst_n;

  assign softRst_n = por_rst_n & bus_rst_n;

  kwd_ctrl #(.HAS_DISABLE(HAS_DISABLE)) u_ctrl (
    .clk         (clk),
    .porRst_n    (por_rst_n),
    .busRst_n    (bus_rst_n),
    .ctlWrEn     (ctl_wr_en),
    .ctlWrData   (ctl_wr_data),
    .cfgWrEn     (cfg_wr_en),
    .cfgWrData   (cfg_wr_data),
    .causeWrEn   (cause_wr_en),
    .causeWrData (cause_wr_data),
    .cntEnabled  (cntEnabled),
    .cntExpire   (cntExpire),
    .cmd         (cntCmd),
    .ctlRdData   (ctl_rd_data),
    .cfgRdData   (cfg_rd_data),
    .causeRdData (cause_rd_data),
    .rstReq      (rst_req),
    .rstKind     (rst_kind)
  );

  kwd_count #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_count (
    .clk     (clk),
    .rst_n   (softRst_n),
    .cmd     (cntCmd),
    .enabled (cntEnabled),
    .expire  (cntExpire)
  );

endmodule

// File: rtl/kwd_checker.sv
`timescale 1ns/1ps
module kwd_checker #(
  parameter bit HAS_DISABLE = 1'b1
) (
  input logic       clk,
  input logic       porRst_n,
  input logic       busRst_n,
  input logic       ctlWrEn,
  input logic [2:0] ctlState,
  input logic       cfgWrEn,
  input logic       cfgNow,
  input logic       cfgKind,
  input logic       causeWrEn,
  input logic       causeWrBit,
  input logic       causeBit,
  input logic       rstReq,
  input logic       expire
);

  // R1: enabling requires a control write while a start was armed
  a_r1_start_needs_arm: assert property (@(posedge clk) disable iff (!porRst_n || !busRst_n)
    $rose(ctlState[0]) |-> $past(ctlWrEn && ctlState[1]));

  // R3 / R4: the timer only stops through a stop commit (stoppable build) or a request
  a_r3_stop_source: assert property (@(posedge clk) disable iff (!porRst_n || !busRst_n)
    $fell(ctlState[0]) |-> (rstReq || $past(ctlWrEn && ctlState[2] && HAS_DISABLE)));

  // R6: request is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!porRst_n || !busRst_n)
    rstReq |=> !rstReq);

  // R6 / R9: request comes from expiry or an immediate-reset write
  a_r6_req_source: assert property (@(posedge clk) disable iff (!porRst_n || !busRst_n)
    $rose(rstReq) |-> $past(expire || (cfgWrEn && cfgNow && cfgKind)));

  // R7: cause bit accompanies every request
  a_r7_cause_with_req: assert property (@(posedge clk) disable iff (!porRst_n)
    rstReq |-> causeBit);

  // R7: cause bit only drops on a write-one-to-clear
  a_r7_cause_clear: assert property (@(posedge clk) disable iff (!porRst_n)
    $fell(causeBit) |-> $past(causeWrEn && causeWrBit));

  // R10: at most one pending action
  a_r10_one_armed: assert property (@(posedge clk) disable iff (!porRst_n)
    $onehot0(ctlState[2:1]));

endmodule

bind keyed_watchdog kwd_checker #(.HAS_DISABLE(HAS_DISABLE)) u_chk (
  .clk        (clk),
  .porRst_n   (por_rst_n),
  .busRst_n   (bus_rst_n),
  .ctlWrEn    (ctl_wr_en),
  .ctlState   (ctl_rd_data[2:0]),
  .cfgWrEn    (cfg_wr_en),
  .cfgNow     (cfg_wr_data[31]),
  .cfgKind    (cfg_wr_data[0]),
  .causeWrEn  (cause_wr_en),
  .causeWrBit (cause_wr_data[5]),
  .causeBit   (cause_rd_data[5]),
  .rstReq     (rst_req),
  .expire     (cntExpire)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;

  localparam int          RLD = 20;
  localparam logic [31:0] K_SA = 32'h1E1E_1E1E;
  localparam logic [31:0] K_SG = 32'hE1E1_E1E1;
  localparam logic [31:0] K_XA = 32'h1F1F_1F1F;
  localparam logic [31:0] K_XG = 32'hF1F1_F1F1;

  logic        clk = 1'b0;
  logic        porRst_n = 1'b0;
  logic        busRst_n = 1'b1;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        causeWrEn = 1'b0;
  logic [31:0] causeWrData = '0;

  logic [31:0] ctlRd0, cfgRd0, causeRd0, ctlRd1, cfgRd1, causeRd1;
  logic        req0, kind0, req1, kind1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  keyed_watchdog #(.CNT_W(32), .RELOAD(32'(RLD)), .HAS_DISABLE(1'b1)) u0 (
    .clk(clk), .por_rst_n(porRst_n), .bus_rst_n(busRst_n),
    .ctl_wr_en(ctlWrEn), .ctl_wr_data(ctlWrData), .ctl_rd_data(ctlRd0),
    .cfg_wr_en(cfgWrEn), .cfg_wr_data(cfgWrData), .cfg_rd_data(cfgRd0),
    .cause_wr_en(causeWrEn), .cause_wr_data(causeWrData), .cause_rd_data(causeRd0),
    .rst_req(req0), .rst_kind(kind0));

  keyed_watchdog #(.CNT_W(32), .RELOAD(32'(RLD)), .HAS_DISABLE(1'b0)) u1 (
    .clk(clk), .por_rst_n(porRst_n), .bus_rst_n(busRst_n),
    .ctl_wr_en(ctlWrEn), .ctl_wr_data(ctlWrData), .ctl_rd_data(ctlRd1),
    .cfg_wr_en(cfgWrEn), .cfg_wr_data(cfgWrData), .cfg_rd_data(cfgRd1),
    .cause_wr_en(causeWrEn), .cause_wr_data(causeWrData), .cause_rd_data(causeRd1),
    .rst_req(req1), .rst_kind(kind1));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrCtl(input logic [31:0] d);
    @(negedge clk); ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk); ctlWrEn = 1'b0; ctlWrData = '0;
  endtask

  task automatic wrCfg(input logic [31:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic wrCause(input logic [31:0] d);
    @(negedge clk); causeWrEn = 1'b1; causeWrData = d;
    @(negedge clk); causeWrEn = 1'b0; causeWrData = '0;
  endtask

  task automatic busReset();
    @(negedge clk); busRst_n = 1'b0;
    tick(2);
    busRst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset_state();
    chk("R11 reset ctl state", ctlRd0, 32'h0);
    chk("R11 reset cfg", cfgRd0, 32'h0);
    chk("R11 reset cause", causeRd0, 32'h0);
    chk("R6 reset request low", {31'b0, req0}, 32'h0);
  endtask

  task automatic t_start_and_expire();
    bit early0 = 0;
    wrCtl(K_SA);
    chk("R10 start armed readback", ctlRd0, 32'h2);
    wrCtl(K_SG);
    chk("R1 enabled after start pair", ctlRd0, 32'h1);
    chk("R1 enabled after start pair (locked build)", ctlRd1, 32'h1);
    for (int k = 0; k < RLD; k++) begin
      tick(1);
      if (req0) early0 = 1;
    end
    chk("R2 no request before RELOAD+1 cycles", {31'b0, early0}, 32'h0);
    tick(1);
    chk("R6 request on expiry", {31'b0, req0}, 32'h1);
    chk("R6 request on expiry (locked build)", {31'b0, req1}, 32'h1);
    chk("R6 enabled cleared on expiry", ctlRd0, 32'h0);
    chk("R7 cause set on expiry", causeRd0, 32'h20);
    tick(1);
    chk("R6 request lasts one cycle", {31'b0, req0}, 32'h0);
    tick(RLD + 3);
    chk("R6 no second request after expiry", {31'b0, req0}, 32'h0);
    wrCause(32'hFFFF_FFDF);
    chk("R7 writing zero to bit 5 keeps cause", causeRd0, 32'h20);
    wrCause(32'h20);
    chk("R7 write-one clears cause", causeRd0, 32'h0);
  endtask

  task automatic t_refresh();
    bit early0 = 0;
    busReset();
    wrCtl(K_SA); wrCtl(K_SG);
    tick(RLD - 6);
    wrCtl(K_SA); wrCtl(K_SG);
    for (int k = 0; k < RLD; k++) begin
      tick(1);
      if (req0) early0 = 1;
    end
    chk("R2 refresh postpones expiry", {31'b0, early0}, 32'h0);
    tick(1);
    chk("R2 request RELOAD+1 after refresh commit", {31'b0, req0}, 32'h1);
    wrCause(32'h20);
  endtask

  task automatic t_ignored();
    busReset();
    wrCtl(K_SG);
    chk("R5 commit without arm ignored", ctlRd0, 32'h0);
    wrCtl(K_SA);
    wrCtl(32'h1234_5678);
    chk("R5 stray word clears armed state", ctlRd0, 32'h0);
    wrCtl(K_SG);
    chk("R5 late commit ignored", ctlRd0, 32'h0);
    wrCtl(K_SA);
    wrCtl(K_XG);
    chk("R5 mismatched commit ignored", ctlRd0, 32'h0);
    wrCtl(K_XA);
    chk("R10 stop armed readback", ctlRd0, 32'h4);
    wrCtl(K_SG);
    chk("R5 start commit after stop arm ignored", ctlRd0, 32'h0);
  endtask

  task automatic t_stop();
    bit any0 = 0;
    busReset();
    wrCtl(K_SA); wrCtl(K_SG);
    tick(5);
    wrCtl(K_XA);
    chk("R10 running with stop armed", ctlRd0, 32'h5);
    chk("R4 stop arm acts as start arm", ctlRd1, 32'h3);
    wrCtl(K_XG);
    chk("R3 stop pair halts timer", ctlRd0, 32'h0);
    chk("R4 stop pair keeps locked timer running", ctlRd1, 32'h1);
    for (int k = 0; k < RLD; k++) begin
      tick(1);
      if (req0) any0 = 1;
    end
    tick(1);
    chk("R4 locked timer expires RELOAD+1 after stop-commit refresh", {31'b0, req1}, 32'h1);
    tick(RLD);
    if (req0) any0 = 1;
    chk("R3 stopped timer never requests", {31'b0, any0}, 32'h0);
    chk("R3 stopped timer cause clear", causeRd0, 32'h0);
  endtask

  task automatic t_config();
    busReset();
    wrCause(32'h20);
    wrCfg(32'h0000_0001);
    chk("R8 kind readback", cfgRd0, 32'h1);
    chk("R8 kind output", {31'b0, kind0}, 32'h1);
    chk("R9 kind write alone requests nothing", {31'b0, req0}, 32'h0);
    wrCfg(32'h8000_0000);
    chk("R9 bit 31 without kind requests nothing", {31'b0, req0}, 32'h0);
    chk("R8 bit 31 reads zero", cfgRd0, 32'h0);
    wrCtl(K_SA); wrCtl(K_SG);
    wrCfg(32'h8000_0001);
    chk("R9 immediate request", {31'b0, req0}, 32'h1);
    chk("R9 immediate request stops timer", ctlRd0, 32'h0);
    chk("R7 cause set on immediate request", causeRd0, 32'h20);
    tick(1);
    chk("R6 immediate request lasts one cycle", {31'b0, req0}, 32'h0);
  endtask

  task automatic t_reset_domains();
    wrCtl(K_SA); wrCtl(K_SG); wrCtl(K_SA);
    chk("R11 state before bus reset", ctlRd0, 32'h3);
    busReset();
    chk("R11 bus reset clears enabled and armed", ctlRd0, 32'h0);
    chk("R7 cause survives bus reset", causeRd0, 32'h20);
    chk("R11 config survives bus reset", cfgRd0, 32'h1);
    @(negedge clk); porRst_n = 1'b0;
    tick(2);
    porRst_n = 1'b1;
    tick(1);
    chk("R7 power-on reset clears cause", causeRd0, 32'h0);
    chk("R11 power-on reset clears config", cfgRd0, 32'h0);
  endtask

  initial begin
    tick(3);
    porRst_n = 1'b1;
    tick(1);
    t_reset_state();
    t_start_and_expire();
    t_refresh();
    t_ignored();
    t_stop();
    t_config();
    t_reset_domains();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule